// File: doc/BRIEF.md
# H-Bridge PWM Regulation Controller

This block drives the four switch enables of one H-bridge. A 2-bit direction command selects one of four modes: coast (all switches off, low-power), reverse, forward or brake. In forward and reverse the bridge is pulse-width modulated. During the on-time the diagonal pair for the commanded direction conducts. During the off-time both high-side switches conduct, so the winding current recirculates. Brake holds both high-side switches on.

The duty cycle is closed-loop. Once per PWM period a digital comparator input reports whether the averaged bridge voltage, divided by four, is below or above the setpoint. The duty then moves up or down by one LSB. A debounced current-limit input overrides this and forces the duty down. Every entry into a driving mode from coast or brake starts the duty at zero, which gives a soft start. A disable input from the fault logic removes all gate drive at once. Each state change that turns a switch off passes through a dead-time gap before the other switch of the same leg may turn on.

The gate controller is a state machine with six states:
- `ST_IDLE`: all switches off.
- `ST_GAP`: dead time, holding only the switches shared by the old and new patterns.
- `ST_FWD_ON`: forward on-time.
- `ST_REV_ON`: reverse on-time.
- `ST_RECIRC`: off-time recirculation.
- `ST_BRAKE`: brake.

Its transitions are:
- Disable goes to `ST_IDLE` from any state.
- A change of target pattern goes to `ST_GAP`.
- `ST_GAP` goes to the target state when its count expires and no held switch must drop. Otherwise it restarts the gap with a smaller held set.
- A target with an identical pattern (recirculate versus brake) is entered directly.

Top module: `hbridge_reg_ctrl`

## Requirements
- R1: While reset is asserted, `gate_o` is 0000 and `duty_o` is 0.
- R2: Command 00 (coast) drives `gate_o` to 0000 and holds `duty_o` at 0; the feedback input has no effect.
- R3: Command 11 (brake) drives `gate_o` to 0101 (both high-side switches on) and holds `duty_o` at 0; the feedback input has no effect.
- R4: Gate bit order is [0] high-side A, [1] low-side A, [2] high-side B, [3] low-side B. Forward (10) on-time is 1001 and reverse (01) on-time is 0110. At the maximum duty value the on-time pattern is held continuously.
- R5: In forward or reverse, the off-time pattern is 0101. With duty 0 the bridge stays in this pattern.
- R6: Entering forward or reverse from coast or brake starts `duty_o` at 0. With feedback low (`fb_low_i`=1) it rises by exactly one per PWM period of `CLK_HZ/PWM_HZ` clocks.
- R7: With feedback low held, `duty_o` saturates at its maximum (255 for 8 bits).
- R8: With `fb_low_i`=0, `duty_o` falls by exactly one per PWM period and stops at 0.
- R9: `ilim_i` high for at least `ILIM_US` microseconds makes `duty_o` fall by one per period even when feedback is low. Shorter pulses do not change the duty.
- R10: One clock after `disable_i` rises, `gate_o` is 0000 and `duty_o` is 0.
- R11: A switch turns on only after both switches of its leg have been off for at least `DEAD_CLKS` clocks. A forward-to-reverse change at full duty shows 0000 for exactly two clocks with `DEAD_CLKS`=2.
- R12: A direct change between forward and reverse keeps the current duty.
- R13: The two switches of one leg are never on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Mode: 00 coast, 01 reverse, 10 forward, 11 brake |
| disable_i | input | 1 | Fault disable, forces all switches off |
| fb_low_i | input | 1 | 1 when averaged output / 4 is below the setpoint |
| ilim_i | input | 1 | Raw current-sense comparator output |
| gate_o | output | 4 | Switch enables {LO_B, HI_B, LO_A, HI_A} |
| duty_o | output | 8 | Present duty value |

## Verification
The hardest case to reach is the current-limit override at saturated duty. The duty must first climb for more than 255 PWM periods with feedback held low. The sense input must then be pulsed just below and held just above the debounce window, so that the only cause of a falling duty is the override. The stimulus uses a short PWM period and ramps to saturation first. It then applies repeated sub-threshold pulses, followed by one long pulse. Each duty change is measured across exactly one period window, so the result does not depend on the phase of the period counter.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        CMD_COAST = 2'b00,
        CMD_REV   = 2'b01,
        CMD_FWD   = 2'b10,
        CMD_BRAKE = 2'b11
    } hb_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_FWD_ON,
        ST_REV_ON,
        ST_RECIRC,
        ST_BRAKE
    } hb_state_e;

    // gate vector bit order: [0] HI_A, [1] LO_A, [2] HI_B, [3] LO_B
    localparam logic [3:0] PAT_OFF  = 4'b0000;
    localparam logic [3:0] PAT_FWD  = 4'b1001;
    localparam logic [3:0] PAT_REV  = 4'b0110;
    localparam logic [3:0] PAT_HIGH = 4'b0101;

    function automatic logic [3:0] state_pattern(hb_state_e s);
        logic [3:0] p;
        unique case (s)
            ST_FWD_ON: p = PAT_FWD;
            ST_REV_ON: p = PAT_REV;
            ST_RECIRC: p = PAT_HIGH;
            ST_BRAKE:  p = PAT_HIGH;
            default:   p = PAT_OFF;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/hb_period_timer.sv
module hb_period_timer #(
    parameter int PERIOD = 2808,
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt_o,
    output logic          tick_o
);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == CW'(PERIOD - 1));
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/hb_duty_reg.sv
module hb_duty_reg #(
    parameter int DUTY_W    = 8,
    parameter int PERIOD    = 2808,
    parameter int ILIM_CLKS = 375,
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1,
    localparam int PW = DUTY_W + CW,
    localparam int IW = $clog2(ILIM_CLKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [CW-1:0]     cnt_i,
    input  logic              drive_i,
    input  logic              fb_low_i,
    input  logic              ilim_i,
    output logic [DUTY_W-1:0] duty_o,
    output logic              pwm_on_o
);

    logic [DUTY_W-1:0] duty_q;
    logic [IW-1:0]     ilim_cnt_q;
    logic              ilim_hold;
    logic [PW-1:0]     prod;
    logic [PW-1:0]     thr;

    // current-limit debounce: saturating run-length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ilim_cnt_q <= '0;
        end else if (!ilim_i) begin
            ilim_cnt_q <= '0;
        end else if (ilim_cnt_q != IW'(ILIM_CLKS)) begin
            ilim_cnt_q <= ilim_cnt_q + 1'b1;
        end
    end

    assign ilim_hold = (ilim_cnt_q == IW'(ILIM_CLKS));

    // one step per period; cleared whenever the bridge is not driving
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q <= '0;
        end else if (!drive_i) begin
            duty_q <= '0;
        end else if (tick_i) begin
            if (ilim_hold || !fb_low_i) begin
                if (duty_q != '0) duty_q <= duty_q - 1'b1;
            end else if (duty_q != '1) begin
                duty_q <= duty_q + 1'b1;
            end
        end
    end

    assign prod     = PW'(duty_q) * PW'(PERIOD);
    assign thr      = prod >> DUTY_W;
    assign pwm_on_o = (duty_q == '1) || (PW'(cnt_i) < thr);
    assign duty_o   = duty_q;

endmodule

// File: rtl/hb_gate_fsm.sv
module hb_gate_fsm #(
    parameter int DEAD_CLKS = 2,
    localparam int DW = (DEAD_CLKS > 2) ? $clog2(DEAD_CLKS) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cmd_i,
    input  logic       dis_i,
    input  logic       pwm_on_i,
    output logic [3:0] gate_o
);
    import hb_pkg::*;

    hb_state_e     state_q, state_d;
    logic [3:0]    mask_q, mask_d;
    logic [DW-1:0] dcnt_q, dcnt_d;
    hb_state_e     tgt_st;
    logic [3:0]    tgt_pat;
    logic [3:0]    cur_pat;

    // target mode from command and PWM phase
    always_comb begin
        unique case (hb_cmd_e'(cmd_i))
            CMD_COAST: begin tgt_st = ST_IDLE;  tgt_pat = PAT_OFF;  end
            CMD_BRAKE: begin tgt_st = ST_BRAKE; tgt_pat = PAT_HIGH; end
            CMD_FWD: begin
                tgt_st  = pwm_on_i ? ST_FWD_ON : ST_RECIRC;
                tgt_pat = pwm_on_i ? PAT_FWD   : PAT_HIGH;
            end
            CMD_REV: begin
                tgt_st  = pwm_on_i ? ST_REV_ON : ST_RECIRC;
                tgt_pat = pwm_on_i ? PAT_REV   : PAT_HIGH;
            end
            default: begin tgt_st = ST_IDLE; tgt_pat = PAT_OFF; end
        endcase
    end

    assign cur_pat = (state_q == ST_GAP) ? mask_q : state_pattern(state_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        mask_d  = mask_q;
        dcnt_d  = dcnt_q;
        if (dis_i) begin
            state_d = ST_IDLE;
            mask_d  = PAT_OFF;
        end else if (state_q == ST_GAP) begin
            if (dcnt_q != '0) begin
                dcnt_d = dcnt_q - 1'b1;
            end else if ((mask_q & ~tgt_pat) == 4'b0000) begin
                state_d = tgt_st;
            end else begin
                mask_d = mask_q & tgt_pat;
                dcnt_d = DW'(DEAD_CLKS - 1);
            end
        end else if (tgt_pat != cur_pat) begin
            state_d = ST_GAP;
            mask_d  = cur_pat & tgt_pat;
            dcnt_d  = DW'(DEAD_CLKS - 1);
        end else begin
            state_d = tgt_st;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= PAT_OFF;
            dcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
            dcnt_q  <= dcnt_d;
        end
    end

    // outputs
    always_comb begin
        gate_o = cur_pat;
    end

endmodule

// File: rtl/hbridge_reg_ctrl.sv
module hbridge_reg_ctrl #(
    parameter int CLK_HZ    = 125_000_000,
    parameter int PWM_HZ    = 44_500,
    parameter int DUTY_W    = 8,
    parameter int DEAD_CLKS = 2,
    parameter int ILIM_US   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_i,
    input  logic              disable_i,
    input  logic              fb_low_i,
    input  logic              ilim_i,
    output logic [3:0]        gate_o,
    output logic [DUTY_W-1:0] duty_o
);
    import hb_pkg::*;

    localparam int PERIOD    = CLK_HZ / PWM_HZ;
    localparam int ILIM_RAW  = (CLK_HZ / 1_000_000) * ILIM_US;
    localparam int ILIM_CLKS = (ILIM_RAW > 0) ? ILIM_RAW : 1;
    localparam int CW        = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] per_cnt;
    logic          per_tick;
    logic          pwm_on;
    logic          drive;

    assign drive = !disable_i &&
                   ((cmd_i == CMD_FWD) || (cmd_i == CMD_REV));

    hb_period_timer #(.PERIOD(PERIOD)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_o  (per_cnt),
        .tick_o (per_tick)
    );

    hb_duty_reg #(
        .DUTY_W    (DUTY_W),
        .PERIOD    (PERIOD),
        .ILIM_CLKS (ILIM_CLKS)
    ) u_duty (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (per_tick),
        .cnt_i    (per_cnt),
        .drive_i  (drive),
        .fb_low_i (fb_low_i),
        .ilim_i   (ilim_i),
        .duty_o   (duty_o),
        .pwm_on_o (pwm_on)
    );

    hb_gate_fsm #(.DEAD_CLKS(DEAD_CLKS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd_i),
        .dis_i    (disable_i),
        .pwm_on_i (pwm_on),
        .gate_o   (gate_o)
    );

endmodule

// File: rtl/hb_reg_chk.sv
module hb_reg_chk #(
    parameter int DUTY_W    = 8,
    parameter int DEAD_CLKS = 2,
    localparam int LW = $clog2(DEAD_CLKS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cmd_i,
    input logic              disable_i,
    input logic              fb_low_i,
    input logic              ilim_i,
    input logic [3:0]        gate_o,
    input logic [DUTY_W-1:0] duty_o
);

    logic          driving;
    logic [LW-1:0] off_a_q, off_b_q;

    assign driving = !disable_i && (cmd_i == 2'b10 || cmd_i == 2'b01);

    // consecutive clocks with both switches of a leg off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_a_q <= LW'(DEAD_CLKS);
            off_b_q <= LW'(DEAD_CLKS);
        end else begin
            if (gate_o[1:0] != 2'b00)             off_a_q <= '0;
            else if (off_a_q != LW'(DEAD_CLKS))   off_a_q <= off_a_q + 1'b1;
            if (gate_o[3:2] != 2'b00)             off_b_q <= '0;
            else if (off_b_q != LW'(DEAD_CLKS))   off_b_q <= off_b_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r13_leg_exclusive: assert (!(gate_o[0] && gate_o[1]) && !(gate_o[2] && gate_o[3]))
                else $error("leg shoot-through");
        end
    end

    a_r10_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        disable_i |=> (gate_o == 4'b0000 && duty_o == '0));

    a_r2_coast_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 2'b00) |=> (gate_o == 4'b0000 && duty_o == '0));

    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        driving |=> (({1'b0, duty_o} == {1'b0, $past(duty_o)}) ||
                     ({1'b0, duty_o} == {1'b0, $past(duty_o)} + (DUTY_W+1)'(1)) ||
                     ({1'b0, duty_o} + (DUTY_W+1)'(1) == {1'b0, $past(duty_o)})));

    a_r8_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (driving && !fb_low_i && !ilim_i && duty_o == '0) |=> (duty_o == '0));

    a_r11_dead_a: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_o[0]) || $rose(gate_o[1])) |-> (off_a_q >= LW'(DEAD_CLKS)));

    a_r11_dead_b: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_o[2]) || $rose(gate_o[3])) |-> (off_b_q >= LW'(DEAD_CLKS)));

endmodule

bind hbridge_reg_ctrl hb_reg_chk #(
    .DUTY_W    (DUTY_W),
    .DEAD_CLKS (DEAD_CLKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_i     (cmd_i),
    .disable_i (disable_i),
    .fb_low_i  (fb_low_i),
    .ilim_i    (ilim_i),
    .gate_o    (gate_o),
    .duty_o    (duty_o)
);

// File: tb/tb_hbridge_reg_ctrl.sv
module tb_hbridge_reg_ctrl;

    localparam int CLK_HZ = 125_000_000;
    localparam int PWM_HZ = 3_906_250;   // 32-clock period
    localparam int PER    = CLK_HZ / PWM_HZ;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cmd;
    logic       dis, fb, ilim;
    logic [3:0] gate;
    logic [7:0] duty;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hbridge_reg_ctrl #(
        .CLK_HZ    (CLK_HZ),
        .PWM_HZ    (PWM_HZ),
        .DUTY_W    (8),
        .DEAD_CLKS (2),
        .ILIM_US   (3)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd),
        .disable_i (dis),
        .fb_low_i  (fb),
        .ilim_i    (ilim),
        .gate_o    (gate),
        .duty_o    (duty)
    );

    typedef struct packed {
        logic [1:0] cmd;
        logic       dis;
        logic       fb;
        logic [3:0] gate;
        logic [7:0] duty;
        logic [3:0] req;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'b00, 1'b0, 1'b0, 4'b0000, 8'd0, 4'd2},   // R2 coast
        '{2'b11, 1'b0, 1'b0, 4'b0101, 8'd0, 4'd3},   // R3 brake
        '{2'b10, 1'b0, 1'b0, 4'b0101, 8'd0, 4'd5},   // R5 forward, duty 0
        '{2'b01, 1'b0, 1'b0, 4'b0101, 8'd0, 4'd5},   // R5 reverse, duty 0
        '{2'b11, 1'b0, 1'b1, 4'b0101, 8'd0, 4'd3},   // R3 feedback ignored
        '{2'b10, 1'b1, 1'b1, 4'b0000, 8'd0, 4'd10},  // R10 disabled forward
        '{2'b00, 1'b0, 1'b1, 4'b0000, 8'd0, 4'd2},   // R2 feedback ignored
        '{2'b01, 1'b1, 1'b0, 4'b0000, 8'd0, 4'd10}   // R10 disabled reverse
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int d;
        int bad;
        rst_n = 1'b0; cmd = 2'b00; dis = 1'b0; fb = 1'b0; ilim = 1'b0;
        wait_n(3);
        chk("R1 gate", gate, 0);
        chk("R1 duty", duty, 0);
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++) begin
            cmd = VECS[i].cmd; dis = VECS[i].dis; fb = VECS[i].fb;
            wait_n(8);
            chk($sformatf("R%0d vec%0d gate", VECS[i].req, i), gate, VECS[i].gate);
            chk($sformatf("R%0d vec%0d duty", VECS[i].req, i), duty, VECS[i].duty);
        end

        // R6 soft start from coast
        dis = 1'b0; cmd = 2'b00; wait_n(4);
        cmd = 2'b10; fb = 1'b1; wait_n(1);
        chk("R6 start near zero", int'(duty <= 1), 1);
        for (int k = 0; k < 2; k++) begin
            d = duty; wait_n(PER);
            chk("R6 one step per period", duty, d + 1);
        end

        // R7 saturation and R4 static forward drive
        wait_n(260 * PER);
        chk("R7 saturated", duty, 255);
        bad = 0;
        for (int k = 0; k < PER; k++) begin
            wait_n(1);
            if (gate != 4'b1001) bad++;
        end
        chk("R4 forward held at full duty", bad, 0);
        wait_n(2 * PER);
        chk("R7 stays saturated", duty, 255);

        // R11 dead time on reversal, R12 duty kept, R4 reverse pattern
        cmd = 2'b01;
        wait_n(1); chk("R11 gap clock 1", gate, 0);
        wait_n(1); chk("R11 gap clock 2", gate, 0);
        wait_n(1); chk("R4 reverse pattern", gate, 4'b0110);
        chk("R12 duty kept on reversal", duty, 255);

        // R9 short sense pulses ignored, long one pulls duty down
        for (int k = 0; k < 5; k++) begin
            ilim = 1'b1; wait_n(100);
            ilim = 1'b0; wait_n(20);
        end
        chk("R9 short pulses ignored", duty, 255);
        ilim = 1'b1; wait_n(400);
        d = duty; wait_n(PER);
        chk("R9 limit lowers duty", duty, d - 1);
        ilim = 1'b0;

        // R8 decrease and floor
        fb = 1'b0; wait_n(2);
        d = duty; wait_n(PER);
        chk("R8 one step down", duty, d - 1);
        wait_n(300 * PER);
        chk("R8 reaches zero", duty, 0);
        wait_n(2 * PER);
        chk("R8 floor holds", duty, 0);
        chk("R5 off-time pattern", gate, 4'b0101);

        // R10 disable
        fb = 1'b1; cmd = 2'b10; wait_n(20 * PER);
        chk("R10 duty built up", int'(duty != 0), 1);
        dis = 1'b1; wait_n(1);
        chk("R10 gate off", gate, 0);
        chk("R10 duty cleared", duty, 0);
        dis = 1'b0; wait_n(1);
        chk("R6 restart after disable", int'(duty <= 1), 1);

        // R6 soft start from brake
        wait_n(10 * PER);
        cmd = 2'b11; wait_n(8);
        chk("R3 brake clears duty", duty, 0);
        cmd = 2'b10; wait_n(1);
        chk("R6 start from brake", int'(duty <= 1), 1);
        d = duty; wait_n(PER);
        chk("R6 step from brake", duty, d + 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule